// File: doc/BRIEF.md
# Dual-Mode Control Word Latch

This block is the control-word front end of a tone signalling device. An 8-bit control word, made of a six-bit tone code, a receive/transmit flag and one auxiliary bit, is collected from the device pins. The word is then moved into an active register that drives the rest of the chip. The pins can be used in two ways, chosen by a mode input. In parallel mode the word is presented on six data pins plus a receive/transmit pin and a tone pin. In serial mode three of the data pins become a three-wire port: enable, data and clock.

All pins are first synchronised into the fast system clock domain. In serial mode, each detected rising edge of the serial clock shifts one bit into a holding register, but only while enable is high. A later rising edge on the load/latch pin copies that register into the active word. In parallel mode the active word follows the pins for as long as load/latch is high. Tying load/latch high therefore gives a processor-free wired setup.

The auxiliary bit changes meaning with the receive/transmit flag. In receive it selects tone detection. In transmit it requests a phase reversal. The block presents the two meanings on separate, already qualified outputs.

Top module: `ctl_word_latch`

## Requirements
- R1: After reset, code_o is 0, rx_tx_o is 0 (receive), tone_en_o, phase_rev_o and latch_err_o are 0.
- R2: In parallel mode (mode_serial=0), while pin_strobe is high the outputs follow the pins within 4 clock cycles: code_o=pin_d, rx_tx_o=pin_rxtx, and the auxiliary bit equals pin_tone. When pin_strobe falls, the value seen while it was high is kept.
- R3: In parallel mode with pin_strobe low, changes on pin_d, pin_rxtx and pin_tone have no effect on the outputs.
- R4: In serial mode, pin_d[5] is an active-high enable, pin_d[4] is data and pin_d[3] is the clock. A bit is taken only on a rising clock edge while enable is high.
- R5: Serial bit order: the first bit goes to code_o[5] and the sixth to code_o[0]. The seventh bit is rx_tx_o and the eighth is the auxiliary bit.
- R6: The shifted word reaches the outputs only on a rising edge of pin_strobe. Before that edge the outputs keep their old value.
- R7: In serial mode, a pin_strobe rising edge that comes before 8 bits have been shifted since enable rose leaves the outputs unchanged and sets latch_err_o high for exactly one cycle. A complete load raises no error.
- R8: Dropping enable clears the bit count, so a partial sequence followed by a fresh enable and 8 bits loads only the fresh 8 bits.
- R9: If more than 8 clocks arrive, the last 8 bits shifted form the word.
- R10: tone_en_o = auxiliary bit AND receive (rx_tx_o=0). phase_rev_o = auxiliary bit AND transmit (rx_tx_o=1).
- R11: In serial mode, pin_d[2:0], pin_rxtx and pin_tone have no effect. A pin_strobe held high does not reload the word after its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_serial | input | 1 | 1 = three-wire serial mode, 0 = parallel mode |
| pin_d | input | 6 | Data pins; in serial mode [5]=enable, [4]=data, [3]=clock |
| pin_rxtx | input | 1 | Parallel receive/transmit pin (1 = transmit) |
| pin_tone | input | 1 | Parallel auxiliary pin |
| pin_strobe | input | 1 | Load/latch pin |
| code_o | output | 6 | Active six-bit tone code |
| rx_tx_o | output | 1 | Active mode flag, 0 = receive, 1 = transmit |
| tone_en_o | output | 1 | Auxiliary bit qualified by receive |
| phase_rev_o | output | 1 | Auxiliary bit qualified by transmit |
| latch_err_o | output | 1 | One-cycle pulse on a rejected short serial load |

## Verification
The parallel path is driven with a table of words. The table mixes alternating, all-ones, all-zero and single-bit codes with every combination of the receive/transmit and auxiliary pins, so a swapped bit or a wrongly qualified auxiliary output gives a different result. Serial words are chosen with asymmetric bit patterns, which exposes reversed shift order and a swap between the seventh and eighth bits. Short sequences, interrupted sequences, over-long sequences and clocks sent with enable low each change the bit count in a different way. Each of them shows whether loading is gated on a full count, whether the count is cleared, and whether the last eight bits are the ones kept. A strobe held high while pins and the serial stream change separates edge-triggered loading from level-triggered loading.

// File: rtl/ctlw_pkg.sv
// Package: shared widths and the control word layout.
// Assumes the code field sits in the most significant bits, so the first
// serial bit shifted in ends up in the code MSB.
package ctlw_pkg;
    localparam int CODE_W = 6;
    localparam int WORD_W = CODE_W + 2;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int PIN_W  = CODE_W + 3;   // data pins, rx/tx, tone, strobe

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rx_tx;   // 0 = receive, 1 = transmit
        logic              aux;     // tone select in receive, phase reverse in transmit
    } ctl_word_t;
endpackage

// File: rtl/ctlw_sync.sv
// Two-flop synchroniser bank. Each bit is synchronised on its own.
// Assumes the inputs are quasi-static pin levels: no bus coherency is implied.
module ctlw_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, stable_q;
        // Two-stage capture of one pin into the clock domain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_i[g];
                stable_q <= meta_q;
            end
        end
        assign sync_o[g] = stable_q;
    end
endmodule

// File: rtl/ctlw_shift.sv
// Serial holding register. Shifts one bit on each rising edge of the
// synchronised serial clock while enable is high, and counts the bits
// (the count saturates at the word width). Dropping enable clears the count.
// Assumes the serial clock is much slower than clk, so each edge is seen.
module ctlw_shift
    import ctlw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    output ctl_word_t        word_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             full_o
);
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sclk_q;
    logic              sclk_rise;

    assign sclk_rise = sclk_i & ~sclk_q;

    // Track the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // Shift data in and keep the saturating bit count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (sclk_rise) begin
            shreg_q <= {shreg_q[WORD_W-2:0], sdata_i};
            if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign word_o = ctl_word_t'(shreg_q);
    assign cnt_o  = cnt_q;
    assign full_o = (cnt_q == CNT_W'(WORD_W));
endmodule

// File: rtl/ctlw_active.sv
// Active control register. In parallel mode it loads the pin word on every
// cycle that the strobe is high. In serial mode it loads the shifted word on
// a strobe rising edge, but only if a full word has been shifted. Otherwise
// it flags a one-cycle error.
// Assumes strobe_i has already been synchronised.
module ctlw_active
    import ctlw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      serial_i,
    input  logic      strobe_i,
    input  ctl_word_t par_word_i,
    input  ctl_word_t ser_word_i,
    input  logic      ser_full_i,
    output ctl_word_t act_o,
    output logic      rise_o,
    output logic      err_o
);
    logic      strobe_q;
    logic      err_q;
    ctl_word_t act_q;

    assign rise_o = strobe_i & ~strobe_q;

    // Remember the previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    // Update the active word according to the selected mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!serial_i && strobe_i) begin
            act_q <= par_word_i;
        end else if (serial_i && rise_o && ser_full_i) begin
            act_q <= ser_word_i;
        end
    end

    // Pulse the error flag for a premature serial load
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= serial_i & rise_o & ~ser_full_i;
    end

    assign act_o = act_q;
    assign err_o = err_q;
endmodule

// File: rtl/ctl_word_latch.sv
// Top: dual-mode control word latch. Synchronises the pins, routes the
// serial roles of pin_d[5:3] to the shifter, and presents the active word
// with the auxiliary bit qualified by the receive/transmit flag.
// Assumes mode_serial is static while words are transferred.
module ctl_word_latch
    import ctlw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_serial,
    input  logic [CODE_W-1:0] pin_d,
    input  logic              pin_rxtx,
    input  logic              pin_tone,
    input  logic              pin_strobe,
    output logic [CODE_W-1:0] code_o,
    output logic              rx_tx_o,
    output logic              tone_en_o,
    output logic              phase_rev_o,
    output logic              latch_err_o
);
    localparam int EN_BIT  = CODE_W - 1;
    localparam int DAT_BIT = CODE_W - 2;
    localparam int CLK_BIT = CODE_W - 3;

    logic [PIN_W-1:0] pin_s;
    ctl_word_t        par_word;
    ctl_word_t        ser_word;
    ctl_word_t        act_word;
    logic [CNT_W-1:0] ser_cnt;
    logic             ser_full;
    logic             strobe_rise;
    logic             ser_en;

    ctlw_sync #(.W(PIN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pin_strobe, pin_tone, pin_rxtx, pin_d}),
        .sync_o  (pin_s)
    );

    assign par_word = '{code: pin_s[CODE_W-1:0], rx_tx: pin_s[CODE_W], aux: pin_s[CODE_W+1]};
    assign ser_en   = mode_serial & pin_s[EN_BIT];

    ctlw_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ser_en),
        .sclk_i  (pin_s[CLK_BIT]),
        .sdata_i (pin_s[DAT_BIT]),
        .word_o  (ser_word),
        .cnt_o   (ser_cnt),
        .full_o  (ser_full)
    );

    ctlw_active u_active (
        .clk        (clk),
        .rst_n      (rst_n),
        .serial_i   (mode_serial),
        .strobe_i   (pin_s[PIN_W-1]),
        .par_word_i (par_word),
        .ser_word_i (ser_word),
        .ser_full_i (ser_full),
        .act_o      (act_word),
        .rise_o     (strobe_rise),
        .err_o      (latch_err_o)
    );

    assign code_o      = act_word.code;
    assign rx_tx_o     = act_word.rx_tx;
    assign tone_en_o   = act_word.aux & ~act_word.rx_tx;
    assign phase_rev_o = act_word.aux &  act_word.rx_tx;
endmodule

// File: rtl/ctl_word_latch_chk.sv
// Checker for ctl_word_latch, attached with bind. It relates the
// synchroniser, shifter and active register over time.
module ctl_word_latch_chk
    import ctlw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_serial,
    input logic             en_s,
    input logic             strobe_s,
    input logic             strobe_rise,
    input ctl_word_t        par_word,
    input ctl_word_t        ser_word,
    input ctl_word_t        act_word,
    input logic [CNT_W-1:0] ser_cnt,
    input logic             latch_err_o
);
    assert_parallel_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_serial && strobe_s) |=> (act_word == $past(par_word)));

    assert_serial_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial && strobe_rise && ser_cnt == CNT_W'(WORD_W)) |=> (act_word == $past(ser_word)));

    assert_serial_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_serial && !strobe_rise) |=> $stable(act_word));

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_err_o |-> $past(mode_serial && strobe_rise && ser_cnt != CNT_W'(WORD_W)));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_err_o |=> !latch_err_o);

    assert_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_serial || !en_s) |=> (ser_cnt == '0));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cnt <= CNT_W'(WORD_W));
endmodule

bind ctl_word_latch ctl_word_latch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_serial (mode_serial),
    .en_s        (pin_s[EN_BIT]),
    .strobe_s    (pin_s[PIN_W-1]),
    .strobe_rise (strobe_rise),
    .par_word    (par_word),
    .ser_word    (ser_word),
    .act_word    (act_word),
    .ser_cnt     (ser_cnt),
    .latch_err_o (latch_err_o)
);

// File: tb/ctl_word_latch_test.sv
`timescale 1ns/1ps
module ctl_word_latch_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_serial = 1'b0;
    logic [5:0] pin_d = '0;
    logic       pin_rxtx = 1'b0;
    logic       pin_tone = 1'b0;
    logic       pin_strobe = 1'b0;
    logic [5:0] code_o;
    logic       rx_tx_o, tone_en_o, phase_rev_o, latch_err_o;

    int n_checks = 0;
    int n_fail   = 0;
    int err_seen = 0;

    always #2.5 clk = ~clk;

    ctl_word_latch uut (
        .clk(clk), .rst_n(rst_n), .mode_serial(mode_serial), .pin_d(pin_d),
        .pin_rxtx(pin_rxtx), .pin_tone(pin_tone), .pin_strobe(pin_strobe),
        .code_o(code_o), .rx_tx_o(rx_tx_o), .tone_en_o(tone_en_o),
        .phase_rev_o(phase_rev_o), .latch_err_o(latch_err_o)
    );

    // Count error pulses seen at the outputs
    always @(posedge clk) if (rst_n && latch_err_o) err_seen++;

    // Parallel vectors: {code, rxtx, tone} stimulus, {code, rx_tx, tone_en, phase_rev} expected
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {6'h2A, 1'b0, 1'b1, 6'h2A, 1'b0, 1'b1, 1'b0},
        {6'h15, 1'b1, 1'b1, 6'h15, 1'b1, 1'b0, 1'b1},
        {6'h3F, 1'b1, 1'b0, 6'h3F, 1'b1, 1'b0, 1'b0},
        {6'h00, 1'b0, 1'b0, 6'h00, 1'b0, 1'b0, 1'b0},
        {6'h01, 1'b0, 1'b1, 6'h01, 1'b0, 1'b1, 1'b0},
        {6'h20, 1'b1, 1'b1, 6'h20, 1'b1, 1'b0, 1'b1}
    };

    function automatic logic [8:0] outs();
        return {code_o, rx_tx_o, tone_en_o, phase_rev_o};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_en(input logic b);
        pin_d[5] = b;
        wait_cyc(4);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            pin_d[4] = v[i];
            wait_cyc(4);
            pin_d[3] = 1'b1;
            wait_cyc(4);
            pin_d[3] = 1'b0;
            wait_cyc(4);
        end
    endtask

    task automatic pulse_strobe();
        pin_strobe = 1'b1;
        wait_cyc(6);
        pin_strobe = 1'b0;
        wait_cyc(6);
    endtask

    task automatic serial_word(input logic [7:0] w);
        set_en(1'b1);
        send_bits({8'h00, w}, 8);
        pulse_strobe();
        set_en(1'b0);
        wait_cyc(4);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int e0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 reset outputs", {23'd0, outs()}, 32'd0);
        check("R1 reset err", {31'd0, latch_err_o}, 32'd0);

        // Table walk, parallel mode (R2, R10)
        for (int k = 0; k < NV; k++) begin
            {pin_d, pin_rxtx, pin_tone} = VEC[k][16:9];
            wait_cyc(2);
            pulse_strobe();
            check("R2/R10 parallel vector", {23'd0, outs()}, {23'd0, VEC[k][8:0]});
        end

        // R3: pins change while strobe low
        pin_d = 6'h0C; pin_rxtx = 1'b0; pin_tone = 1'b0;
        wait_cyc(8);
        check("R3 strobe low ignored", {23'd0, outs()}, {23'd0, 6'h20, 3'b101});

        // R2: strobe held high, outputs follow pins
        pin_strobe = 1'b1;
        wait_cyc(6);
        check("R2 follow a", {23'd0, outs()}, {23'd0, 6'h0C, 3'b000});
        pin_d = 6'h33; pin_rxtx = 1'b1; pin_tone = 1'b1;
        wait_cyc(6);
        check("R2 follow b", {23'd0, outs()}, {23'd0, 6'h33, 3'b101});
        pin_strobe = 1'b0;
        wait_cyc(6);
        pin_d = 6'h00; pin_rxtx = 1'b0; pin_tone = 1'b0;
        wait_cyc(6);
        check("R2 value kept after strobe falls", {23'd0, outs()}, {23'd0, 6'h33, 3'b101});

        // Serial mode
        pin_d = 6'h00;
        mode_serial = 1'b1;
        wait_cyc(6);

        // R5/R6: word 1011_0110 -> code 2D, transmit, aux 0
        e0 = err_seen;
        set_en(1'b1);
        send_bits(16'h00B6, 8);
        wait_cyc(4);
        check("R6 not visible before strobe", {23'd0, outs()}, {23'd0, 6'h33, 3'b101});
        pulse_strobe();
        set_en(1'b0);
        check("R5 serial order", {23'd0, outs()}, {23'd0, 6'h2D, 3'b100});
        check("R7 no error on full load", err_seen - e0, 0);

        // R10: receive with aux -> tone enable
        serial_word(8'hCD);
        check("R10 receive aux", {23'd0, outs()}, {23'd0, 6'h33, 3'b010});
        // R10: transmit with aux -> phase reverse
        serial_word(8'h03);
        check("R10 transmit aux", {23'd0, outs()}, {23'd0, 6'h00, 3'b101});

        // R7: short load rejected
        e0 = err_seen;
        set_en(1'b1);
        send_bits(16'h001F, 5);
        pulse_strobe();
        set_en(1'b0);
        check("R7 short load ignored", {23'd0, outs()}, {23'd0, 6'h00, 3'b101});
        check("R7 single error pulse", err_seen - e0, 1);

        // R4: clocks with enable low shift nothing
        e0 = err_seen;
        send_bits(16'h00FF, 8);
        set_en(1'b1);
        pulse_strobe();
        set_en(1'b0);
        check("R4 no shift without enable", {23'd0, outs()}, {23'd0, 6'h00, 3'b101});
        check("R4 error on empty load", err_seen - e0, 1);

        // R8: partial, enable drop, fresh 8 bits
        set_en(1'b1);
        send_bits(16'h0007, 3);
        set_en(1'b0);
        serial_word(8'hA5);
        check("R8 count cleared", {23'd0, outs()}, {23'd0, 6'h29, 3'b010});

        // R9: ten clocks, last eight kept (0x5E)
        set_en(1'b1);
        send_bits(16'h035E, 10);
        pulse_strobe();
        set_en(1'b0);
        check("R9 last eight bits", {23'd0, outs()}, {23'd0, 6'h17, 3'b100});

        // R11: strobe held high, unused pins and new shifts have no effect
        e0 = err_seen;
        set_en(1'b1);
        send_bits(16'h0081, 8);
        pin_strobe = 1'b1;
        wait_cyc(6);
        check("R11 load on rising edge", {23'd0, outs()}, {23'd0, 6'h20, 3'b010});
        pin_d[2:0] = 3'b111; pin_rxtx = 1'b1; pin_tone = 1'b1;
        send_bits(16'h00FE, 8);
        wait_cyc(6);
        check("R11 held strobe and unused pins ignored", {23'd0, outs()}, {23'd0, 6'h20, 3'b010});
        pin_strobe = 1'b0;
        set_en(1'b0);
        wait_cyc(6);
        check("R11 no error", err_seen - e0, 0);

        // R1: reset again clears the active word
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 reset clears word", {23'd0, outs()}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule